// File: doc/BRIEF.md
# Three-Phase Sled Stepping Decoder

This block turns the sled control code from a servo controller into per-phase switch commands for a sled motor output stage. Each of the three phases (U, V, W) gets a separate high-side enable and low-side enable. When both enables are off, that phase is open (high impedance). A mode input selects how the 3-bit code is read. In stepping mode it is a six-step commutation pattern for a three-phase motor. In bridge mode, U and V form a full bridge controlled by code bits 0 and 1, and W is a half bridge controlled by code bit 2.

All enables are registered on the system clock. Each phase has its own dead-time guard. A phase never switches from one side to the other without staying open for a set number of clocks first.

The block also returns three position-comparator results to the controller. They pass through only in stepping mode and only outside standby. Standby means the start/stop input and the mute input are both low. An active-low mute opens every phase, whatever the mode and code.

Top module: `sled_step_decoder`

## Requirements
- R1: In stepping mode with mute high, code {sel[2],sel[1],sel[0]} selects phase drive (bit 0 = U, 1 = V, 2 = W) as follows: 000 gives U high, V low; 001 gives U high, W low; 011 gives V high, W low; 010 gives V high, U low; 110 gives W high, U low; 100 gives W high, V low. The phase not named is open.
- R2: In stepping mode, codes 101 and 111 leave all three phases open. 111 is the code seen when the inputs are left at their idle high level.
- R3: In bridge mode, {sel[1],sel[0]} = 01 drives U high and V low, 10 drives V high and U low, 00 drives U and V both low, and 11 leaves U and V open.
- R4: In bridge mode, W is driven high when sel[2] is 1 and driven low when sel[2] is 0.
- R5: With mute_n low, every high and low enable is 0 from the next clock edge on, in either mode and for any code.
- R6: Enables follow their inputs one clock edge after the inputs are applied. After reset, all enables and feedback outputs are 0.
- R7: If a phase's target reverses directly between high and low, the phase is open for exactly DEAD_CYC (default 2) clocks before the new side is enabled.
- R8: If the target reverses after an open period shorter than DEAD_CYC clocks, the phase stays open until it has been open for DEAD_CYC clocks in total.
- R9: A phase that returns to the same side it last drove does so with no added dead time.
- R10: In stepping mode, outside standby, fb_out equals cmp_in one clock edge later. This holds while muted as long as run is high.
- R11: In bridge mode, fb_out is 0.
- R12: In standby (run low and mute_n low), fb_out is 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_mode | input | 1 | 1 = three-phase stepping, 0 = bridge plus half bridge |
| mute_n | input | 1 | Active-low mute; opens all phases |
| run | input | 1 | Start/stop input; low together with mute_n low means standby |
| sel | input | 3 | Sled control code, bit 0 first input |
| cmp_in | input | 3 | Position comparator results (bit 0 = U) |
| drv_hi | output | 3 | High-side enables (bit 0 = U, 1 = V, 2 = W) |
| drv_lo | output | 3 | Low-side enables (bit 0 = U, 1 = V, 2 = W) |
| fb_out | output | 3 | Gated comparator feedback |

## Verification
The bench sweeps every code under both modes and both mute levels, and checks the enables against tables it holds itself. A swapped table row would put a phase on the wrong side. A missing mute gate would leave a phase driven while muted.

Dead time is checked in three cases. In a direct reversal, a missing guard would let the new side turn on one clock after the old side turned off. In a reversal across a single open clock, a guard that looked only at the previous cycle would give one open clock instead of two. When a phase returns to the side it last drove, an over-eager guard would insert an extra delay. Feedback gating is checked in stepping mode, bridge mode and standby, including the muted-but-running case that must still pass the comparator values through.

// File: rtl/sled_pkg.sv
package sled_pkg;
    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_HI  = 2'd1,
        DRV_LO  = 2'd2
    } drv_e;

    localparam int PHASES = 3;
endpackage

// File: rtl/sled_target_map.sv
module sled_target_map
    import sled_pkg::*;
(
    input  logic              step_mode,
    input  logic              mute_n,
    input  logic [PHASES-1:0] sel,
    output logic [PHASES-1:0] want_hi,
    output logic [PHASES-1:0] want_lo
);
    always_comb begin
        want_hi = '0;
        want_lo = '0;
        if (mute_n) begin
            if (step_mode) begin
                unique case (sel)
                    3'b000: begin want_hi = 3'b001; want_lo = 3'b010; end
                    3'b001: begin want_hi = 3'b001; want_lo = 3'b100; end
                    3'b011: begin want_hi = 3'b010; want_lo = 3'b100; end
                    3'b010: begin want_hi = 3'b010; want_lo = 3'b001; end
                    3'b110: begin want_hi = 3'b100; want_lo = 3'b001; end
                    3'b100: begin want_hi = 3'b100; want_lo = 3'b010; end
                    default: begin want_hi = '0; want_lo = '0; end
                endcase
            end else begin
                // full bridge on U/V
                want_hi[0] = sel[0] & ~sel[1];
                want_lo[1] = sel[0] & ~sel[1];
                want_hi[1] = sel[1] & ~sel[0];
                want_lo[0] = (sel[1] & ~sel[0]) | ~(sel[0] | sel[1]);
                if (~(sel[0] | sel[1])) want_lo[1] = 1'b1;
                // half bridge on W
                want_hi[2] = sel[2];
                want_lo[2] = ~sel[2];
            end
        end
    end
endmodule

// File: rtl/sled_phase_gate.sv
module sled_phase_gate
    import sled_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic want_lo,
    output logic hi_en,
    output logic lo_en
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

    typedef struct packed {
        drv_e          drv;
        drv_e          side;
        logic [CW-1:0] offc;
    } gate_st_t;

    gate_st_t st_d, st_q;
    drv_e     tgt;
    logic [CW-1:0] offc_inc;

    always_comb begin
        tgt      = want_hi ? DRV_HI : (want_lo ? DRV_LO : DRV_OFF);
        offc_inc = (st_q.offc == DEAD_V) ? DEAD_V : st_q.offc + 1'b1;
        st_d     = st_q;
        if (tgt == DRV_OFF || (st_q.drv != DRV_OFF && st_q.drv != tgt)) begin
            st_d.drv  = DRV_OFF;
            st_d.offc = (st_q.drv == DRV_OFF) ? offc_inc : CW'(1);
        end else if (st_q.drv == DRV_OFF) begin
            if (st_q.side == DRV_OFF || st_q.side == tgt || st_q.offc >= DEAD_V) begin
                st_d.drv  = tgt;
                st_d.side = tgt;
            end else begin
                st_d.offc = offc_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{drv: DRV_OFF, side: DRV_OFF, offc: DEAD_V};
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_en = (st_q.drv == DRV_HI);
    assign lo_en = (st_q.drv == DRV_LO);

    assert_hi_then_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en |=> !lo_en);
    assert_lo_then_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_en |=> !hi_en);
    assert_no_drive_without_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!want_hi && !want_lo) |=> (!hi_en && !lo_en));
endmodule

// File: rtl/sled_fb_gate.sv
module sled_fb_gate
    import sled_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_mode,
    input  logic              standby,
    input  logic [PHASES-1:0] cmp_in,
    output logic [PHASES-1:0] fb_q
);
    logic [PHASES-1:0] fb_d;

    always_comb begin
        fb_d = (step_mode && !standby) ? cmp_in : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fb_q <= '0;
        else        fb_q <= fb_d;
    end

    assert_fb_low_bridge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step_mode |=> (fb_q == '0));
    assert_fb_low_standby_R12: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (fb_q == '0));
endmodule

// File: rtl/sled_step_decoder.sv
module sled_step_decoder
    import sled_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_mode,
    input  logic        mute_n,
    input  logic        run,
    input  logic [2:0]  sel,
    input  logic [2:0]  cmp_in,
    output logic [2:0]  drv_hi,
    output logic [2:0]  drv_lo,
    output logic [2:0]  fb_out
);
    logic [PHASES-1:0] want_hi, want_lo;
    logic              standby;

    assign standby = !run && !mute_n;

    sled_target_map u_map (
        .step_mode (step_mode),
        .mute_n    (mute_n),
        .sel       (sel),
        .want_hi   (want_hi),
        .want_lo   (want_lo)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        sled_phase_gate #(.DEAD_CYC(DEAD_CYC)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .want_hi (want_hi[p]),
            .want_lo (want_lo[p]),
            .hi_en   (drv_hi[p]),
            .lo_en   (drv_lo[p])
        );
    end

    sled_fb_gate u_fb (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_mode (step_mode),
        .standby   (standby),
        .cmp_in    (cmp_in),
        .fb_q      (fb_out)
    );

    assert_mute_opens_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |=> (drv_hi == '0 && drv_lo == '0));
    assert_step_bad_code_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_mode && sel[0] && sel[2]) |=> (drv_hi == '0 && drv_lo == '0));
    assert_fb_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_mode && !standby) |=> (fb_out == $past(cmp_in)));
endmodule

// File: tb/sled_step_decoder_test.sv
module sled_step_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_mode = 1'b1;
    logic       mute_n = 1'b0;
    logic       run = 1'b1;
    logic [2:0] sel = 3'b111;
    logic [2:0] cmp_in = 3'b000;
    logic [2:0] drv_hi, drv_lo, fb_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sled_step_decoder uut (
        .clk(clk), .rst_n(rst_n), .step_mode(step_mode), .mute_n(mute_n),
        .run(run), .sel(sel), .cmp_in(cmp_in),
        .drv_hi(drv_hi), .drv_lo(drv_lo), .fb_out(fb_out)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // returns {lo[2:0], hi[2:0]}, bit 0 = U
    function automatic logic [5:0] expect_drv(bit stp, bit mu, logic [2:0] c);
        logic [2:0] h, l;
        h = 3'b000; l = 3'b000;
        if (mu) begin
            if (stp) begin
                case (c)
                    3'b000: begin h = 3'b001; l = 3'b010; end
                    3'b001: begin h = 3'b001; l = 3'b100; end
                    3'b011: begin h = 3'b010; l = 3'b100; end
                    3'b010: begin h = 3'b010; l = 3'b001; end
                    3'b110: begin h = 3'b100; l = 3'b001; end
                    3'b100: begin h = 3'b100; l = 3'b010; end
                    default: ;
                endcase
            end else begin
                case (c[1:0])
                    2'b01: begin h[0] = 1'b1; l[1] = 1'b1; end
                    2'b10: begin h[1] = 1'b1; l[0] = 1'b1; end
                    2'b00: begin l[0] = 1'b1; l[1] = 1'b1; end
                    default: ;
                endcase
                if (c[2]) h[2] = 1'b1; else l[2] = 1'b1;
            end
        end
        return {l, h};
    endfunction

    task automatic drive(input bit stp, input bit mu, input bit rn, input logic [2:0] c,
                         input logic [2:0] cm);
        @(negedge clk);
        step_mode = stp; mute_n = mu; run = rn; sel = c; cmp_in = cm;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] e;
        repeat (2) @(posedge clk);
        #1;
        check("R6 reset state", {fb_out, drv_lo, drv_hi}, 9'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R10 R11: full sweep; each vector preceded by a long muted gap
        for (int m = 0; m < 2; m++) begin
            for (int mu = 0; mu < 2; mu++) begin
                for (int c = 0; c < 8; c++) begin
                    drive(1'b1, 1'b0, 1'b1, 3'b111, 3'b000);
                    repeat (3) tick();
                    drive(m[0], mu[0], 1'b1, c[2:0], ~c[2:0]);
                    tick();
                    e = expect_drv(m[0], mu[0], c[2:0]);
                    check(m ? (mu ? "R1/R2 step map" : "R5 mute step")
                            : (mu ? "R3/R4 bridge map" : "R5 mute bridge"),
                          {fb_out, drv_lo, drv_hi},
                          {(m[0] ? ~c[2:0] : 3'b000), e});
                end
            end
        end

        // R7: direct reversal on U and V
        drive(1'b1, 1'b0, 1'b1, 3'b111, 3'b000);
        repeat (3) tick();
        drive(1'b1, 1'b1, 1'b1, 3'b000, 3'b000);
        tick();
        check("R7 start U hi V lo", {3'b0, drv_lo, drv_hi}, {3'b0, 3'b010, 3'b001});
        drive(1'b1, 1'b1, 1'b1, 3'b010, 3'b000);
        tick();
        check("R7 dead clock 1", {3'b0, drv_lo, drv_hi}, 9'b0);
        tick();
        check("R7 dead clock 2", {3'b0, drv_lo, drv_hi}, 9'b0);
        tick();
        check("R7 reversed", {3'b0, drv_lo, drv_hi}, {3'b0, 3'b001, 3'b010});

        // R8: U low -> one open clock -> U high needs one more open clock
        drive(1'b1, 1'b1, 1'b1, 3'b011, 3'b000);
        tick();
        check("R8 U open", {3'b0, drv_lo, drv_hi}, {3'b0, 3'b100, 3'b010});
        drive(1'b1, 1'b1, 1'b1, 3'b001, 3'b000);
        tick();
        check("R8 U held open", {3'b0, drv_lo, drv_hi}, {3'b0, 3'b100, 3'b000});
        tick();
        check("R8 U high", {3'b0, drv_lo, drv_hi}, {3'b0, 3'b100, 3'b001});

        // R9: same side resumes immediately
        drive(1'b1, 1'b1, 1'b1, 3'b101, 3'b000);
        tick();
        check("R9 all open", {3'b0, drv_lo, drv_hi}, 9'b0);
        drive(1'b1, 1'b1, 1'b1, 3'b001, 3'b000);
        tick();
        check("R9 resume", {3'b0, drv_lo, drv_hi}, {3'b0, 3'b100, 3'b001});

        // R10 R12: standby vs muted-but-running feedback
        drive(1'b1, 1'b0, 1'b0, 3'b000, 3'b101);
        tick();
        check("R12 standby fb", {fb_out, drv_lo, drv_hi}, 9'b0);
        drive(1'b0, 1'b0, 1'b0, 3'b000, 3'b110);
        tick();
        check("R12 standby bridge fb", {fb_out, drv_lo, drv_hi}, 9'b0);
        drive(1'b1, 1'b0, 1'b1, 3'b000, 3'b101);
        tick();
        check("R10 muted running fb", {fb_out, drv_lo, drv_hi}, {3'b101, 6'b0});
        drive(1'b1, 1'b1, 1'b1, 3'b111, 3'b011);
        tick();
        check("R10 fb update", {fb_out, drv_lo, drv_hi}, {3'b011, 6'b0});
        drive(1'b0, 1'b1, 1'b1, 3'b011, 3'b111);
        tick();
        check("R11 bridge fb", {fb_out, 6'b0}, 9'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule